// File: doc/BRIEF.md
# Flash Read-State Command Decoder

This block holds the read state of a parallel NOR flash interface and selects where each read gets its data. The bus writes an 8-bit command code. Depending on the code, later reads return one of four sources: the memory array, a small identifier table, the status register or a query table. The read state stays in force across any number of reads and changes only when a recognised command is written.

A program command (0x40) arms the block. The next bus write is the data to be programmed, and that write starts a busy period of fixed length. After a program, the block stays in status mode. Array data is returned again only after an explicit read-array command. Unknown codes leave the state as it was and raise an error flag.

The controller holds five named states:
- `S_ARRAY`, `S_IDENT`, `S_STATUS`, `S_QUERY`: the four read states.
- `S_PGM_WAIT`: armed by a program command and waiting for the data write. Reads in this state return status.

The transitions are:
- **select**: any read state goes to the state that the written code names.
- **arm**: 0x40 goes to `S_PGM_WAIT`.
- **launch**: the data write in `S_PGM_WAIT` goes to `S_STATUS` and starts the busy timer.
- **hold**: an unknown code, a write while busy, a write without chip enable, or no write at all leaves the state unchanged.

Top module: `flash_read_state`

## Requirements
- R1: A qualified write sets `rd_mode` as follows. 0xFF selects array (0), 0x90 selects identifier (1), 0x70 selects status (2) and 0x98 selects query (3). A qualified write is `chip_en`=1 and `wr_stb`=1 on a rising clock edge, while not busy and not waiting for program data. The new mode is visible after that edge.
- R2: While `rst_n` is low, and after it is released, the block is in array mode (`rd_mode`=0) with `busy`=0 and `cmd_err`=0.
- R3: `rd_mode` and `cmd_err` change only on a qualified write. A strobe with `chip_en`=0 has no effect.
- R4: In array mode with `chip_en`=1, `rd_data` equals `arr_data`. After a program operation, array data is not returned until 0xFF is written.
- R5: Any other code written in a read state leaves `rd_mode` unchanged and sets `cmd_err`. The next accepted write clears `cmd_err`.
- R6: Writing 0x40 makes `rd_mode` read status (2). The next qualified write, whatever its value, is the program data. It keeps status mode and raises `busy` for exactly PGM_CYCLES clock cycles after its edge.
- R7: Writes made while `busy`=1 change neither `rd_mode` nor `cmd_err`.
- R8: In identifier mode, `addr` offset 0 returns MFR_CODE (default 0x0089) and offset 1 returns DEV_CODE (default 0x881E). Every other offset returns 0.
- R9: In status mode, `rd_data` bit 7 is 1 when idle and 0 when busy. All other bits are 0.
- R10: In query mode, offsets 0x10, 0x11, 0x12 and 0x13 return 0x0051, 0x0052, 0x0059 and 0x0001. All other offsets return 0.
- R11: With `chip_en`=0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable; qualifies reads and writes |
| wr_stb | input | 1 | Write strobe, one cycle per bus write |
| addr | input | AW (8) | Read/write address |
| wdata | input | 8 | Command or program data |
| arr_data | input | DW (16) | Data sensed from the memory array |
| rd_data | output | DW (16) | Read data after source selection |
| rd_mode | output | 2 | Current read mode (0 array, 1 ident, 2 status, 3 query) |
| busy | output | 1 | Program in progress |
| cmd_err | output | 1 | Last command code was not recognised |

## Verification
The bench sweeps every address in each read mode and compares the result with tables computed in the bench. These sweeps catch a wrong offset decode or a source leaking across modes.

The bench counts the busy window edge by edge, so a timer that is off by one cycle shows up. It writes 0xFF as program data to check that a data write is not decoded as a command; a design that did so would fall back to array mode. It also issues commands while busy and strobes without chip enable, to catch a design that lets those change the state. Finally, it confirms that array data stays hidden after a program until read-array is written, and that an unknown code sets the error flag without moving the state.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [2:0] {
        S_ARRAY    = 3'd0,
        S_IDENT    = 3'd1,
        S_STATUS   = 3'd2,
        S_QUERY    = 3'd3,
        S_PGM_WAIT = 3'd4
    } frs_state_e;

    typedef enum logic [1:0] {
        M_ARRAY  = 2'd0,
        M_IDENT  = 2'd1,
        M_STATUS = 2'd2,
        M_QUERY  = 2'd3
    } frs_mode_e;

    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_IDENT  = 8'h90;
    localparam logic [7:0] OP_RD_STATUS = 8'h70;
    localparam logic [7:0] OP_RD_QUERY  = 8'h98;
    localparam logic [7:0] OP_PROGRAM   = 8'h40;

    localparam int STATUS_READY_BIT = 7;

    // Read mode presented for each controller state
    function automatic frs_mode_e mode_of(input frs_state_e s);
        frs_mode_e m;
        unique case (s)
            S_ARRAY:    m = M_ARRAY;
            S_IDENT:    m = M_IDENT;
            S_STATUS:   m = M_STATUS;
            S_QUERY:    m = M_QUERY;
            S_PGM_WAIT: m = M_STATUS;
            default:    m = M_ARRAY;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/frs_cmd_fsm.sv
module frs_cmd_fsm
    import frs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_fire,
    input  logic       busy,
    input  logic [7:0] code,
    output frs_mode_e  mode,
    output logic       pgm_start,
    output logic       pgm_wait,
    output logic       cmd_err
);

    frs_state_e st_q, st_nxt;
    logic       err_q, err_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_ARRAY;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            err_q <= err_nxt;
        end
    end

    // Next-state decode
    always_comb begin
        st_nxt    = st_q;
        err_nxt   = err_q;
        pgm_start = 1'b0;
        if (wr_fire && !busy) begin
            unique case (st_q)
                S_PGM_WAIT: begin
                    // launch: data write, never decoded as a command
                    st_nxt    = S_STATUS;
                    pgm_start = 1'b1;
                    err_nxt   = 1'b0;
                end
                default: begin
                    err_nxt = 1'b0;
                    unique case (code)
                        OP_RD_ARRAY:  st_nxt = S_ARRAY;
                        OP_RD_IDENT:  st_nxt = S_IDENT;
                        OP_RD_STATUS: st_nxt = S_STATUS;
                        OP_RD_QUERY:  st_nxt = S_QUERY;
                        OP_PROGRAM:   st_nxt = S_PGM_WAIT;
                        default:      err_nxt = 1'b1;
                    endcase
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mode     = mode_of(st_q);
        pgm_wait = (st_q == S_PGM_WAIT);
        cmd_err  = err_q;
    end

endmodule

// File: rtl/frs_busy_timer.sv
module frs_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/frs_rdmux.sv
module frs_rdmux
    import frs_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 8,
    parameter logic [15:0] MFR_CODE = 16'h0089,
    parameter logic [15:0] DEV_CODE = 16'h881E
) (
    input  logic          chip_en,
    input  frs_mode_e     mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] arr_data,
    input  logic          busy,
    output logic [DW-1:0] rd_data
);

    localparam int OW = (AW < 8) ? AW : 8;

    logic [OW-1:0] ofs;
    logic [DW-1:0] id_word, q_word, st_word, sel;

    assign ofs = addr[OW-1:0];

    function automatic logic [15:0] query_word(input logic [7:0] o);
        logic [15:0] w;
        unique case (o)
            8'h10:   w = 16'h0051;
            8'h11:   w = 16'h0052;
            8'h12:   w = 16'h0059;
            8'h13:   w = 16'h0001;
            default: w = 16'h0000;
        endcase
        return w;
    endfunction

    always_comb begin
        id_word = '0;
        if (ofs == OW'(0))      id_word = DW'(MFR_CODE);
        else if (ofs == OW'(1)) id_word = DW'(DEV_CODE);
    end

    always_comb begin
        q_word = DW'(query_word(8'(ofs)));
    end

    always_comb begin
        st_word = '0;
        st_word[STATUS_READY_BIT] = !busy;
    end

    always_comb begin
        unique case (mode)
            M_ARRAY:  sel = arr_data;
            M_IDENT:  sel = id_word;
            M_STATUS: sel = st_word;
            M_QUERY:  sel = q_word;
            default:  sel = '0;
        endcase
        rd_data = chip_en ? sel : '0;
    end

endmodule

// File: rtl/flash_read_state.sv
module flash_read_state
    import frs_pkg::*;
#(
    parameter int          DW         = 16,
    parameter int          AW         = 8,
    parameter int          PGM_CYCLES = 8,
    parameter logic [15:0] MFR_CODE   = 16'h0089,
    parameter logic [15:0] DEV_CODE   = 16'h881E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    rd_mode,
    output logic          busy,
    output logic          cmd_err
);

    logic      wr_fire;
    logic      pgm_start;
    logic      pgm_wait;
    frs_mode_e mode;

    assign wr_fire = chip_en && wr_stb;

    frs_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .busy     (busy),
        .code     (wdata),
        .mode     (mode),
        .pgm_start(pgm_start),
        .pgm_wait (pgm_wait),
        .cmd_err  (cmd_err)
    );

    frs_busy_timer #(.CYCLES(PGM_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(pgm_start),
        .busy (busy)
    );

    frs_rdmux #(
        .DW(DW), .AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_mux (
        .chip_en (chip_en),
        .mode    (mode),
        .addr    (addr),
        .arr_data(arr_data),
        .busy    (busy),
        .rd_data (rd_data)
    );

    assign rd_mode = mode;

endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_en,
    input logic          wr_stb,
    input logic [7:0]    wdata,
    input logic [DW-1:0] arr_data,
    input logic [DW-1:0] rd_data,
    input logic [1:0]    rd_mode,
    input logic          busy,
    input logic          cmd_err,
    input logic          pgm_wait
);

    logic fire, known;
    assign fire  = chip_en && wr_stb;
    assign known = (wdata == 8'hFF) || (wdata == 8'h90) || (wdata == 8'h70) ||
                   (wdata == 8'h98) || (wdata == 8'h40);

    AST_RESET_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_mode == 2'd0 && !busy && !cmd_err)); // R2
    AST_FF_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !busy && !pgm_wait && wdata == 8'hFF) |=> rd_mode == 2'd0); // R1
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(rd_mode) && $stable(cmd_err))); // R3
    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && rd_mode == 2'd0) |-> rd_data == arr_data); // R4
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !busy && !pgm_wait && !known) |=> (cmd_err && $stable(rd_mode))); // R5
    AST_PGM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !busy && pgm_wait) |=> (busy && rd_mode == 2'd2)); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && busy) |=> ($stable(rd_mode) && $stable(cmd_err))); // R7
    AST_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && rd_mode == 2'd2) |-> (rd_data[7] == !busy && $countones(rd_data) <= 1)); // R9
    AST_DESELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> rd_data == '0); // R11

endmodule

bind flash_read_state frs_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .wr_stb  (wr_stb),
    .wdata   (wdata),
    .arr_data(arr_data),
    .rd_data (rd_data),
    .rd_mode (rd_mode),
    .busy    (busy),
    .cmd_err (cmd_err),
    .pgm_wait(pgm_wait)
);

// File: tb/flash_read_state_bench.sv
`timescale 1ns/1ps
module flash_read_state_bench;

    localparam int DW  = 16;
    localparam int AW  = 8;
    localparam int PGM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [DW-1:0] arr_data;
    logic [DW-1:0] rd_data;
    logic [1:0]    rd_mode;
    logic          busy, cmd_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign arr_data = {addr, ~addr};

    flash_read_state u_flash_read_state (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .arr_data(arr_data), .rd_data(rd_data),
        .rd_mode(rd_mode), .busy(busy), .cmd_err(cmd_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] code, input logic ce);
        chip_en = ce;
        wr_stb  = 1'b1;
        wdata   = code;
        @(posedge clk);
        @(negedge clk);
        wr_stb  = 1'b0;
        chip_en = 1'b1;
    endtask

    function automatic logic [15:0] exp_ident(input int a);
        if (a == 0) return 16'h0089;
        if (a == 1) return 16'h881E;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] exp_query(input int a);
        if (a >= 16 && a <= 19) return (a == 16) ? 16'h0051 : (a == 17) ? 16'h0052 :
                                       (a == 18) ? 16'h0059 : 16'h0001;
        return 16'h0000;
    endfunction

    task automatic sweep(input int mode);
        int errs = 0;
        logic [15:0] e;
        for (int a = 0; a < 256; a++) begin
            addr = AW'(a);
            #0.5;
            unique case (mode)
                0: e = {a[7:0], ~a[7:0]};
                1: e = exp_ident(a);
                default: e = exp_query(a);
            endcase
            if (rd_data !== e) begin
                errs++;
                if (errs < 4)
                    $display("FAIL %s addr=%0h: actual=%0h expected=%0h",
                             mode == 0 ? "R4" : mode == 1 ? "R8" : "R10", a, rd_data, e);
            end
        end
        total++;
        if (errs != 0) bad++;
        addr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 mode in reset", rd_mode, 0);
        rst_n = 1'b1;
        chip_en = 1'b1;
        @(negedge clk);
        chk("R2 mode", rd_mode, 0);
        chk("R2 busy", busy, 0);
        chk("R2 err", cmd_err, 0);
        sweep(0); // R4 array

        wr(8'h90, 1'b1);
        chk("R1 ident mode", rd_mode, 1);
        sweep(1); // R8
        wr(8'h98, 1'b1);
        chk("R1 query mode", rd_mode, 3);
        sweep(2); // R10
        wr(8'h70, 1'b1);
        chk("R1 status mode", rd_mode, 2);
        chk("R9 idle status", rd_data, 16'h0080);
        wr(8'hFF, 1'b1);
        chk("R1 array mode", rd_mode, 0);

        // R3: strobe without chip enable
        wr(8'h90, 1'b0);
        chk("R3 deselected write", rd_mode, 0);
        chk("R3 err untouched", cmd_err, 0);

        // R11: deselected reads
        chip_en = 1'b0;
        addr = 8'h05;
        #0.5;
        chk("R11 deselected read", rd_data, 0);
        chip_en = 1'b1;

        // R5: unknown codes
        wr(8'h98, 1'b1);
        wr(8'h12, 1'b1);
        chk("R5 mode kept", rd_mode, 3);
        chk("R5 err set", cmd_err, 1);
        repeat (3) @(negedge clk);
        chk("R3 err held", cmd_err, 1);
        wr(8'h90, 1'b1);
        chk("R5 err cleared", cmd_err, 0);
        chk("R5 next mode", rd_mode, 1);

        // R6: program sequence, data 0xFF is not a command
        wr(8'h40, 1'b1);
        chk("R6 armed reads status", rd_mode, 2);
        chk("R6 armed not busy", busy, 0);
        wr(8'hFF, 1'b1);
        chk("R6 status after data", rd_mode, 2);
        for (int i = 0; i < PGM; i++) begin
            chk("R6 busy window", busy, 1);
            if (i == 0) chk("R9 busy status", rd_data, 16'h0000);
            @(negedge clk);
        end
        chk("R6 busy ends", busy, 0);
        chk("R9 ready again", rd_data, 16'h0080);
        chk("R4 array hidden after program", rd_mode, 2);

        // R7: commands while busy are ignored
        wr(8'h40, 1'b1);
        wr(8'h33, 1'b1);
        chk("R7 launched", busy, 1);
        wr(8'hFF, 1'b1);
        chk("R7 mode during busy", rd_mode, 2);
        wr(8'h55, 1'b1);
        chk("R7 err during busy", cmd_err, 0);
        repeat (PGM) @(negedge clk);
        chk("R7 idle", busy, 0);
        chk("R7 still status", rd_mode, 2);
        wr(8'hFF, 1'b1);
        chk("R4 array restored", rd_mode, 0);
        addr = 8'h3C;
        #0.5;
        chk("R4 array data", rd_data, {8'h3C, 8'hC3});

        // R2: reset from a non-array state
        wr(8'h98, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset returns array", rd_mode, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule